// File: doc/BRIEF.md
# Return-Address Stack with Interrupt Hold-Off

This block keeps the return addresses of a small processor core in a private hardware stack. The core pulses a call strobe with the current program counter to save it, and pulses a return strobe to get the most recent saved address back. The stack holds a fixed number of levels. Neither the stored entries nor the pointer can be reached through any data path.

An interrupt request is latched into a pending flag. The block grants it with a one-cycle acknowledge, and the grant itself saves the program counter presented on that cycle. While every level is occupied, the grant is held back and the request stays pending. Once a return frees a level, the interrupt is granted. A call made on a full stack is still accepted: the oldest entry is discarded, so the newest addresses are the ones kept.

The top of the stack is always visible on the return-address output. Priority logic among interrupt sources and program-counter sequencing belong to the surrounding core.

Top module: `retaddr_stack`

## Requirements
- R1: After a synchronous active-low reset, the stack is empty, the return-address output reads 0, and the acknowledge output is low.
- R2: A call strobe (with no return strobe) stores the 13-bit PC input. From the next cycle, the return-address output shows that value.
- R3: A return strobe on a non-empty stack removes the top entry. From the next cycle, the output shows the entry stored just before it (last-in, first-out).
- R4: Up to 8 calls are held, and 8 returns give them back in reverse order.
- R5: A call on a full stack still stores the PC and discards the oldest entry. The stack stays full and keeps the newest 8 addresses.
- R6: A request pulse sets a pending flag. In any cycle where the flag is set, the stack is not full and no return strobe is present, the acknowledge output is high for that cycle. That cycle stores the PC input as a return address and clears the flag, unless a new request arrives in the same cycle.
- R7: While the stack is full, the acknowledge output stays low and the pending flag is kept. In the cycle after a return frees a level, the acknowledge output goes high.
- R8: A return strobe on an empty stack leaves it empty. A later call followed by a return then behaves as on a fresh stack.
- R9: When the call and return strobes arrive in the same cycle, only the return takes effect and the PC input is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| call_i | input | 1 | Save the PC input (subroutine call) |
| ret_i | input | 1 | Discard the top entry (return) |
| pc_i | input | 13 | Program counter to be saved |
| ret_pc_o | output | 13 | Current top-of-stack return address |
| irq_req_i | input | 1 | Interrupt request pulse |
| irq_ack_o | output | 1 | Interrupt granted; the PC input is saved this cycle |

## Verification
The assertions take the strobes to be sampled only on clock edges out of reset. They accept a call and a grant in the same cycle as a single save, because both carry the same PC. The bench drives call, return and request together in its random phase. It therefore covers call-with-return collisions and requests that arrive while the stack is full or while a grant is in progress. It reads the return-address output only while the reference model holds entries, or before the first save after reset, because the contents of an emptied slot are left unspecified.

// File: rtl/rstk_pkg.sv
// Shared sizing for the return-address stack.
// Assumes DEPTH is at least 2.
package rstk_pkg;
    localparam int unsigned RSTK_PC_W  = 13;
    localparam int unsigned RSTK_DEPTH = 8;
endpackage

// File: rtl/rstk_ring.sv
// Register file of DEPTH return-address slots, one write port and one read port.
// Assumes wr_idx and rd_idx are always below DEPTH.
module rstk_ring #(
    parameter int unsigned PC_W  = 13,
    parameter int unsigned DEPTH = 8,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [PC_W-1:0]  wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [PC_W-1:0]  rd_data
);
    logic [PC_W-1:0] slots [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        logic [PC_W-1:0] val_q;
        // Each slot loads when the write index selects it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                val_q <= '0;
            else if (wr_en && wr_idx == IDX_W'(s))
                val_q <= wr_data;
        end
        assign slots[s] = val_q;
    end

    // Asynchronous read of the selected slot.
    assign rd_data = slots[rd_idx];
endmodule

// File: rtl/rstk_level.sv
// Top index and occupancy count of the circular stack.
// A save on a full stack moves the top onward and overwrites the oldest slot.
// A removal on an empty stack does nothing.
// Assumes push and pop are never high together (the top resolves that).
module rstk_level #(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned IDX_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    output logic [IDX_W-1:0] top_idx,
    output logic [IDX_W-1:0] next_idx,
    output logic             full,
    output logic             empty
);
    logic [IDX_W-1:0] top_q;
    logic [IDX_W-1:0] prev_idx;
    logic [CNT_W-1:0] cnt_q;

    // Wrapping neighbours of the current top slot.
    always_comb begin
        next_idx = (top_q == IDX_W'(DEPTH - 1)) ? '0 : top_q + 1'b1;
        prev_idx = (top_q == '0) ? IDX_W'(DEPTH - 1) : top_q - 1'b1;
    end

    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign top_idx = top_q;

    // Move the top index and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= IDX_W'(DEPTH - 1);
            cnt_q <= '0;
        end else if (pop) begin
            if (!empty) begin
                top_q <= prev_idx;
                cnt_q <= cnt_q - 1'b1;
            end
        end else if (push) begin
            top_q <= next_idx;
            if (!full)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // R4
    count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !full) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
    // R5
    stay_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && full) |=> full);
    // R8
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty) |=> (empty && $stable(top_q)));
endmodule

// File: rtl/rstk_irq_gate.sv
// Pending-interrupt flag and grant.
// A grant is given only when a level is free and no return is in progress.
// Assumes the request is a pulse or a level that is sampled on each clock edge.
module rstk_irq_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_req,
    input  logic full,
    input  logic pop,
    output logic ack
);
    logic pend_q;

    assign ack = pend_q && !full && !pop;

    // Latch requests and keep them until they are granted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else
            pend_q <= irq_req || (pend_q && !ack);
    end

    // R7
    hold_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && full && !pop) |=> pend_q);
    // R6
    grant_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !irq_req) |=> !pend_q);
endmodule

// File: rtl/retaddr_stack.sv
// Return-address stack: a ring store, a level tracker and an interrupt gate.
// A call or a grant saves pc_i. A return removes the top entry, and a return wins over a save.
// Assumes a call and a grant in the same cycle refer to the same PC.
module retaddr_stack
    import rstk_pkg::*;
#(
    parameter int unsigned PC_W  = RSTK_PC_W,
    parameter int unsigned DEPTH = RSTK_DEPTH,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            call_i,
    input  logic            ret_i,
    input  logic [PC_W-1:0] pc_i,
    output logic [PC_W-1:0] ret_pc_o,
    input  logic            irq_req_i,
    output logic            irq_ack_o
);
    logic             save;
    logic             full;
    logic             empty;
    logic [IDX_W-1:0] top_idx;
    logic [IDX_W-1:0] next_idx;

    // A save happens on a call or a grant, unless a return is present.
    assign save = (call_i || irq_ack_o) && !ret_i;

    rstk_irq_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_req (irq_req_i),
        .full    (full),
        .pop     (ret_i),
        .ack     (irq_ack_o)
    );

    rstk_level #(.DEPTH(DEPTH)) u_level (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (save),
        .pop      (ret_i),
        .top_idx  (top_idx),
        .next_idx (next_idx),
        .full     (full),
        .empty    (empty)
    );

    rstk_ring #(.PC_W(PC_W), .DEPTH(DEPTH)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (save),
        .wr_idx  (next_idx),
        .wr_data (pc_i),
        .rd_idx  (top_idx),
        .rd_data (ret_pc_o)
    );

    // R2
    saved_on_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        save |=> ret_pc_o == $past(pc_i));
    // R9
    ret_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && call_i && !empty) |=> !full);
endmodule

// File: tb/sim_retaddr_stack.sv
`timescale 1ns/1ps
module sim_retaddr_stack;
    localparam int PC_W  = 13;
    localparam int DEPTH = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            call_i = 1'b0;
    logic            ret_i = 1'b0;
    logic [PC_W-1:0] pc_i = '0;
    logic [PC_W-1:0] ret_pc_o;
    logic            irq_req_i = 1'b0;
    logic            irq_ack_o;

    int n_cmp = 0;
    int n_bad = 0;
    int q[$];
    bit pend = 1'b0;
    bit fresh = 1'b1;
    bit done = 1'b0;

    always #2 clk = ~clk;

    retaddr_stack u0 (
        .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i), .pc_i(pc_i),
        .ret_pc_o(ret_pc_o), .irq_req_i(irq_req_i), .irq_ack_o(irq_ack_o)
    );

    // One clock: drive inputs, compare outputs, then advance the model.
    task automatic step(input bit c, input bit r, input bit irq, input int pc, input string tag);
        bit exp_ack;
        int exp_pc;
        @(negedge clk);
        call_i = c; ret_i = r; irq_req_i = irq; pc_i = PC_W'(pc);
        #1;
        exp_ack = pend && (q.size() < DEPTH) && !r;
        n_cmp++;
        if (irq_ack_o !== exp_ack) begin
            n_bad++;
            $display("FAIL %s ack actual=%0b expected=%0b", tag, irq_ack_o, exp_ack);
        end
        if (q.size() > 0 || fresh) begin
            exp_pc = (q.size() > 0) ? q[$] : 0;
            n_cmp++;
            if (ret_pc_o !== PC_W'(exp_pc)) begin
                n_bad++;
                $display("FAIL %s pc actual=%0h expected=%0h", tag, ret_pc_o, exp_pc);
            end
        end
        @(posedge clk);
        if (r) begin
            if (q.size() > 0) void'(q.pop_back());
        end else if (c || exp_ack) begin
            q.push_back(pc & ((1 << PC_W) - 1));
            fresh = 1'b0;
            if (q.size() > DEPTH) void'(q.pop_front());
        end
        pend = irq || (pend && !exp_ack);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        step(0, 0, 0, 0, "R1");
        step(0, 0, 0, 0, "R1");
        for (int i = 0; i < 3; i++) step(1, 0, 0, 'h100 + i, "R2");
        step(0, 0, 0, 0, "R2");
        for (int i = 0; i < 3; i++) step(0, 1, 0, 0, "R3");
        step(0, 1, 0, 0, "R8");
        step(0, 1, 0, 0, "R8");
        step(1, 0, 0, 'h0abc, "R8");
        step(0, 0, 0, 0, "R8");
        step(0, 1, 0, 0, "R8");
        for (int i = 0; i < DEPTH; i++) step(1, 0, 0, 'h200 + i, "R4");
        for (int i = 0; i < DEPTH; i++) step(0, 1, 0, 0, "R4");
        for (int i = 0; i < DEPTH + 3; i++) step(1, 0, 0, 'h300 + i, "R5");
        step(0, 0, 0, 0, "R5");
        for (int i = 0; i < DEPTH; i++) step(0, 1, 0, 0, "R5");
        step(0, 0, 1, 0, "R6");
        step(0, 0, 0, 'h1fff, "R6");
        step(0, 0, 0, 0, "R6");
        for (int i = 0; i < DEPTH - 1; i++) step(1, 0, 0, 'h400 + i, "R7");
        step(0, 0, 1, 0, "R7");
        for (int i = 0; i < 4; i++) step(0, 0, 0, 'h777, "R7");
        step(0, 1, 0, 0, "R7");
        step(0, 0, 0, 'h555, "R7");
        step(0, 0, 0, 0, "R7");
        step(1, 1, 0, 'h666, "R9");
        step(0, 0, 0, 0, "R9");
        step(1, 1, 0, 'h667, "R9");
        step(0, 0, 0, 0, "R9");
        for (int i = 0; i < 600; i++) begin
            int roll = $urandom_range(0, 9);
            step(roll < 5, roll >= 4 && roll < 8, $urandom_range(0, 5) == 0,
                 $urandom_range(0, 8191), "R2");
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule